// File: doc/BRIEF.md
# Sticky Floating-Point Status Register

This block keeps the 16-bit status word of a floating-point unit. Each cycle it takes one-cycle pulses for the six arithmetic exceptions, a mask vector, stack overflow and underflow pulses, and a compare result carrying four condition-code bits. It also accepts three control commands: clear-exceptions, initialize, and restore. Restore supplies a complete replacement word. Exception flags are sticky. A flag latches whether or not it is masked, and only an exception that arrives while unmasked raises the error-summary bit and the handler request.

The word is laid out as follows:

- Bits 5..0 hold the exceptions: invalid (bit 0), denormal, zero-divide, overflow, underflow and precision (bit 5).
- Bit 6 is the stack-fault flag.
- Bit 7 is the error summary.
- Bits 8, 9 and 10 are condition codes C0, C1 and C2.
- Bits 13..11 show the top-of-stack pointer, taken straight from an input.
- Bit 14 is C3.
- Bit 15 is a compatibility copy of bit 7.

The upper byte is also driven on its own port. This lets the condition codes be copied into the low byte of an integer flags register.

Top module: `fp_status_word`

## Requirements
- R1: After a synchronous reset every stored bit is 0. The word then reads only the top-of-stack field, and the handler request is low.
- R2: An exception pulse on `exc_evt[i]` sets word bit i (bit 0 invalid through bit 5 precision) at the next clock edge. The bit stays set until a clear, initialize or restore command.
- R3: A pulse whose mask bit is 1 sets only its flag. A pulse whose mask bit is 0 also sets bit 7 and drives `handler_req` high from the next edge. Both stay set until a clear, initialize or restore command.
- R4: Bit 15 always reads the same value as bit 7, including after a restore that supplies a different bit 15.
- R5: A stack overflow or underflow pulse sets bit 6 and bit 0. It writes C1 (bit 9) to 1 for overflow and to 0 for underflow, and overflow wins if both pulse together. It sets bit 7 if `exc_mask[0]` is 0. A later invalid exception does not clear bit 6.
- R6: A compare update loads `cmp_cc` = {C3,C2,C1,C0} into bits 14, 10, 9 and 8 in one cycle. If a stack fault happens in the same cycle, C1 comes from the fault instead.
- R7: Clear zeroes bits 7..0 and bit 15 and leaves bits 8..14 unchanged. Events in the same cycle are merged in after the clear.
- R8: Initialize zeroes every stored bit. It takes priority over restore, and events in the same cycle are dropped.
- R9: Restore (without initialize) loads bits 10..0 and bit 14 from `restore_word`. Bit 15 then follows the loaded bit 7, and events in the same cycle are dropped.
- R10: Bits 13..11 of the word always show `top_ptr` in the same cycle. They are never stored, so a restore cannot change them.
- R11: `cc_byte` always equals bits 15..8 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_evt | input | 6 | One-cycle exception pulses, bit 0 invalid through bit 5 precision |
| exc_mask | input | 6 | 1 = exception masked |
| stk_ovf | input | 1 | Stack overflow pulse |
| stk_unf | input | 1 | Stack underflow pulse |
| cmp_we | input | 1 | Load condition codes from a compare |
| cmp_cc | input | 4 | Compare result {C3,C2,C1,C0} |
| top_ptr | input | 3 | Current top-of-stack pointer |
| clear_cmd | input | 1 | Clear exceptions |
| init_cmd | input | 1 | Initialize the word |
| restore_cmd | input | 1 | Overwrite the word from `restore_word` |
| restore_word | input | 16 | Replacement word for restore |
| status_word | output | 16 | Full status word |
| cc_byte | output | 8 | Upper byte of the status word |
| handler_req | output | 1 | Exception handler should be invoked |

## Verification
The bench checks three kinds of collision.

**Command against event in the same cycle.** Clear with an event, restore with events, and initialize together with restore all collide here. A design with the wrong priority would either lose the event that follows a clear, or keep events that initialize and restore must drop.

**Stack fault against compare in the same cycle.** A fault and a compare land together, and separately both fault pulses fire at once. A wrong design leaks the compare's C1 or the underflow polarity into bit 9.

**Mask handling and restore.** The bench checks that a masked exception still latches its flag while leaving the summary low. It also restores a word whose bit 15 disagrees with bit 7; a design that stores bit 15 separately would then show a summary mismatch.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
    localparam int EXC_N   = 6;
    localparam int TOP_W   = 3;
    localparam int WORD_W  = 16;
    localparam int SF_POS  = EXC_N;
    localparam int ES_POS  = EXC_N + 1;
    localparam int C0_POS  = 8;
    localparam int C1_POS  = 9;
    localparam int C2_POS  = 10;
    localparam int TOP_LSB = 11;
    localparam int C3_POS  = TOP_LSB + TOP_W;
    localparam int B_POS   = WORD_W - 1;

    typedef enum logic [1:0] {
        CTL_HOLD  = 2'd0,
        CTL_CLEAR = 2'd1,
        CTL_WIPE  = 2'd2,
        CTL_LOAD  = 2'd3
    } ctl_e;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
        logic c0;
    } cc_t;

    function automatic ctl_e pick_ctl(input logic init, input logic load, input logic clr);
        if (init)      return CTL_WIPE;
        else if (load) return CTL_LOAD;
        else if (clr)  return CTL_CLEAR;
        else           return CTL_HOLD;
    endfunction

    function automatic logic events_live(input ctl_e c);
        return (c == CTL_HOLD) || (c == CTL_CLEAR);
    endfunction
endpackage

// File: rtl/fpsw_flag_bank.sv
module fpsw_flag_bank
    import fpsw_pkg::*;
#(
    parameter int N = EXC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_e         ctl,
    input  logic [N-1:0] exc_evt,
    input  logic [N-1:0] exc_mask,
    input  logic         fault,
    input  logic [N-1:0] ld_flags,
    input  logic         ld_sf,
    input  logic         ld_es,
    output logic [N-1:0] flags_q,
    output logic         sf_q,
    output logic         es_q
);
    localparam logic [N-1:0] INV_ONEHOT = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] base_flags, fresh, flags_d;
    logic         base_sf, base_es, sf_d, es_d, live;

    always_comb begin
        case (ctl)
            CTL_HOLD: begin
                base_flags = flags_q;
                base_sf    = sf_q;
                base_es    = es_q;
            end
            CTL_LOAD: begin
                base_flags = ld_flags;
                base_sf    = ld_sf;
                base_es    = ld_es;
            end
            default: begin
                base_flags = '0;
                base_sf    = 1'b0;
                base_es    = 1'b0;
            end
        endcase
        live    = events_live(ctl);
        fresh   = live ? (exc_evt | (fault ? INV_ONEHOT : '0)) : '0;
        flags_d = base_flags | fresh;
        sf_d    = base_sf | (live & fault);
        es_d    = base_es | (|(fresh & ~exc_mask));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            sf_q    <= 1'b0;
            es_q    <= 1'b0;
        end else begin
            flags_q <= flags_d;
            sf_q    <= sf_d;
            es_q    <= es_d;
        end
    end

    // R2
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl == CTL_HOLD) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R3
    unmasked_es_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl == CTL_HOLD || ctl == CTL_CLEAR) && |(exc_evt & ~exc_mask)) |=> es_q);

    // R3
    masked_no_es_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl == CTL_HOLD && !es_q && ((exc_evt & ~exc_mask) == '0) && !(fault && !exc_mask[0]))
        |=> !es_q);

    // R5
    fault_sets_sf_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl == CTL_HOLD || ctl == CTL_CLEAR) && fault) |=> (sf_q && flags_q[0]));
endmodule

// File: rtl/fpsw_cc_bank.sv
module fpsw_cc_bank
    import fpsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_e ctl,
    input  logic cmp_we,
    input  cc_t  cmp_cc,
    input  logic ovf,
    input  logic unf,
    input  cc_t  ld_cc,
    output cc_t  cc_q
);
    cc_t cc_d;

    always_comb begin
        case (ctl)
            CTL_WIPE: cc_d = '0;
            CTL_LOAD: cc_d = ld_cc;
            default: begin
                cc_d = cc_q;
                if (cmp_we)     cc_d = cmp_cc;
                if (ovf || unf) cc_d.c1 = ovf;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cc_q <= '0;
        else     cc_q <= cc_d;
    end

    // R5
    fault_c1_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl == CTL_HOLD || ctl == CTL_CLEAR) && ovf) |=> cc_q.c1);

    // R5
    fault_c1_unf_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl == CTL_HOLD || ctl == CTL_CLEAR) && unf && !ovf) |=> !cc_q.c1);

    // R7
    clear_keeps_cc_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl == CTL_CLEAR && !cmp_we && !ovf && !unf) |=> (cc_q == $past(cc_q)));
endmodule

// File: rtl/fp_status_word.sv
module fp_status_word
    import fpsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [EXC_N-1:0]    exc_evt,
    input  logic [EXC_N-1:0]    exc_mask,
    input  logic                stk_ovf,
    input  logic                stk_unf,
    input  logic                cmp_we,
    input  logic [3:0]          cmp_cc,
    input  logic [TOP_W-1:0]    top_ptr,
    input  logic                clear_cmd,
    input  logic                init_cmd,
    input  logic                restore_cmd,
    input  logic [WORD_W-1:0]   restore_word,
    output logic [WORD_W-1:0]   status_word,
    output logic [7:0]          cc_byte,
    output logic                handler_req
);
    ctl_e             ctl;
    logic [EXC_N-1:0] flags;
    logic             sf, es;
    cc_t              cc, ld_cc;
    logic             unused_restore_bits;

    assign ctl   = pick_ctl(init_cmd, restore_cmd, clear_cmd);
    assign ld_cc = '{c3: restore_word[C3_POS], c2: restore_word[C2_POS],
                     c1: restore_word[C1_POS], c0: restore_word[C0_POS]};
    assign unused_restore_bits = ^{restore_word[B_POS], restore_word[C3_POS-1:TOP_LSB]};

    fpsw_flag_bank #(.N(EXC_N)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .exc_evt  (exc_evt),
        .exc_mask (exc_mask),
        .fault    (stk_ovf | stk_unf),
        .ld_flags (restore_word[EXC_N-1:0]),
        .ld_sf    (restore_word[SF_POS]),
        .ld_es    (restore_word[ES_POS]),
        .flags_q  (flags),
        .sf_q     (sf),
        .es_q     (es)
    );

    fpsw_cc_bank u_cc (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .cmp_we (cmp_we),
        .cmp_cc (cmp_cc),
        .ovf    (stk_ovf),
        .unf    (stk_unf),
        .ld_cc  (ld_cc),
        .cc_q   (cc)
    );

    assign status_word = {es, cc.c3, top_ptr, cc.c2, cc.c1, cc.c0, es, sf, flags};
    assign cc_byte     = status_word[WORD_W-1:8];
    assign handler_req = es;

    // R8
    init_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        init_cmd |=> ((status_word & 16'hC7FF) == 16'h0000));

    // R9
    restore_load_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_cmd && !init_cmd) |=>
        (status_word[C2_POS:0] == $past(restore_word[C2_POS:0]) &&
         status_word[C3_POS] == $past(restore_word[C3_POS])));
endmodule

// File: tb/test_fp_status_word.sv
module test_fp_status_word;
    typedef struct packed {
        logic        clr;
        logic        init;
        logic        ld;
        logic [5:0]  evt;
        logic [5:0]  mask;
        logic        ovf;
        logic        unf;
        logic        cwe;
        logic [3:0]  cc;
        logic [15:0] load;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    // top_ptr held at 3'b101 (0x2800) through the table
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,6'h01,6'h3F,1'b0,1'b0,1'b0,4'h0,16'h0000,16'h2801}, // R3 masked invalid
        '{1'b0,1'b0,1'b0,6'h00,6'h3F,1'b0,1'b0,1'b0,4'h0,16'h0000,16'h2801}, // R2 sticky
        '{1'b0,1'b0,1'b0,6'h04,6'h3B,1'b0,1'b0,1'b0,4'h0,16'h0000,16'hA885}, // R3 R4 unmasked zdiv
        '{1'b0,1'b0,1'b0,6'h00,6'h3F,1'b0,1'b0,1'b1,4'hB,16'h0000,16'hEB85}, // R6 compare
        '{1'b1,1'b0,1'b0,6'h10,6'h3F,1'b0,1'b0,1'b0,4'h0,16'h0000,16'h6B10}, // R7 clear + event
        '{1'b0,1'b0,1'b0,6'h00,6'h3F,1'b0,1'b1,1'b0,4'h0,16'h0000,16'h6951}, // R5 underflow
        '{1'b0,1'b0,1'b0,6'h00,6'h3E,1'b1,1'b0,1'b0,4'h0,16'h0000,16'hEBD1}, // R5 overflow unmasked
        '{1'b0,1'b0,1'b1,6'h3F,6'h00,1'b0,1'b0,1'b0,4'h0,16'h1234,16'h2A34}, // R9 restore drops events
        '{1'b0,1'b1,1'b1,6'h01,6'h00,1'b0,1'b0,1'b0,4'h0,16'hFFFF,16'h2800}, // R8 init over restore
        '{1'b0,1'b0,1'b1,6'h00,6'h3F,1'b0,1'b0,1'b0,4'h0,16'h4485,16'hEC85}, // R9 R4 bit15 follows bit7
        '{1'b0,1'b0,1'b0,6'h00,6'h3F,1'b0,1'b1,1'b1,4'h6,16'h0000,16'hACC5}  // R6 R5 fault beats compare C1
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  exc_evt = '0, exc_mask = 6'h3F;
    logic        stk_ovf = 1'b0, stk_unf = 1'b0, cmp_we = 1'b0;
    logic [3:0]  cmp_cc = '0;
    logic [2:0]  top_ptr = 3'b101;
    logic        clear_cmd = 1'b0, init_cmd = 1'b0, restore_cmd = 1'b0;
    logic [15:0] restore_word = '0;
    logic [15:0] status_word;
    logic [7:0]  cc_byte;
    logic        handler_req;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fp_status_word i_fp_status_word (
        .clk(clk), .rst(rst), .exc_evt(exc_evt), .exc_mask(exc_mask),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf), .cmp_we(cmp_we), .cmp_cc(cmp_cc),
        .top_ptr(top_ptr), .clear_cmd(clear_cmd), .init_cmd(init_cmd),
        .restore_cmd(restore_cmd), .restore_word(restore_word),
        .status_word(status_word), .cc_byte(cc_byte), .handler_req(handler_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        exc_evt = '0; stk_ovf = 1'b0; stk_unf = 1'b0; cmp_we = 1'b0;
        clear_cmd = 1'b0; init_cmd = 1'b0; restore_cmd = 1'b0;
    endtask

    task automatic full_check(input string req, input logic [15:0] exp);
        chk(req, status_word, exp);
        chk("R11 cc_byte", {8'h00, cc_byte}, {8'h00, exp[15:8]});
        chk("R3 handler_req", {15'h0, handler_req}, {15'h0, exp[7]});
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        full_check("R1 reset", 16'h2800);

        for (int k = 0; k < NV; k++) begin
            clear_cmd = VECS[k].clr; init_cmd = VECS[k].init; restore_cmd = VECS[k].ld;
            exc_evt = VECS[k].evt; exc_mask = VECS[k].mask;
            stk_ovf = VECS[k].ovf; stk_unf = VECS[k].unf;
            cmp_we = VECS[k].cwe; cmp_cc = VECS[k].cc; restore_word = VECS[k].load;
            @(negedge clk);
            full_check($sformatf("R2-table vec%0d", k), VECS[k].exp);
            idle();
        end

        // R10 top pointer shows combinationally
        top_ptr = 3'b010;
        #1;
        chk("R10 top field", {13'h0, status_word[13:11]}, 16'h0002);

        // R8 init, then R5 both faults together: overflow wins
        init_cmd = 1'b1;
        @(negedge clk);
        full_check("R8 init", 16'h1000);
        idle();
        exc_mask = 6'h3F; stk_ovf = 1'b1; stk_unf = 1'b1;
        @(negedge clk);
        full_check("R5 both faults", 16'h1241);
        idle();

        // R5 invalid event does not clear stack fault
        exc_evt = 6'h01;
        @(negedge clk);
        full_check("R5 sf kept", 16'h1241);
        idle();

        // R1 synchronous reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        full_check("R1 reset again", 16'h1000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule